// File: doc/BRIEF.md
# Quarter-Tile Outer-Product Accumulate Sequencer

This block runs one quarter-tile sum-of-outer-products accumulate on a square tile of 16-bit accumulators. It does no arithmetic itself. It walks the tile, fetches the row and column byte pairs from the vector register file, reads the old accumulator, and hands each element to a separate 2-way FP8 dot-product-accumulate unit through a request/response handshake. When the unit answers, the block writes the returned sum back into the same tile slot. The vector length `VLEN` is a parameter. The quadrant side is `DIM = VLEN/32`, and the tile has `2*DIM` rows and `2*DIM` columns.

The tile is covered as four quarter outer products. Quadrant q has row half `q/2` and column half `q%2`. Its rows start at `(q/2)*DIM` and its columns start at `(q%2)*DIM`. Each side can source from one register or from a pair. When a side uses a pair, the register chosen for the first (row) operand follows the quadrant's column half, and the register chosen for the second (column) operand follows its row half. The register file and the tile storage are outside the block. Both are reached through combinational read ports.

A start pulse latches the two 3-bit register fields and the two pair selectors. The block then runs until a one-cycle done pulse.

Top module: `qtile_mop_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `req_valid` and `tile_wr_en` are all 0, and a `rsp_valid` seen while idle causes no tile write.
- R2: Elements are visited quadrant 0 to 3, and row-major inside each quadrant. For quadrant q, local row r and local column c, `tile_addr` = ((q/2)*DIM + r)*(2*DIM) + (q%2)*DIM + c.
- R3: `vrf_a_idx` = 2*n_field + (n_pair ? q%2 : 0), so bit 4 is 0 and bit 0 is 0 unless a pair is in use.
- R4: `vrf_b_idx` = 16 + 2*m_field + (m_pair ? q/2 : 0), so bit 4 is always 1.
- R5: `req_row_op` is bits [16*ri+15:16*ri] of `vrf_a_data`, where ri is the absolute tile row. `req_col_op` is bits [16*ci+15:16*ci] of `vrf_b_data`, where ci is the absolute tile column. Byte 2*idx sits in the low 8 bits and byte 2*idx+1 in the high 8 bits.
- R6: `req_acc` equals the tile content at `tile_addr` during the request. At the end of the operation every tile slot holds the sum returned for it.
- R7: After a request the block holds its position until `rsp_valid`. In the cycle where `rsp_valid` is high during the wait, `tile_wr_en` is 1, `tile_wr_data` equals `rsp_sum`, and `tile_addr` is still the requested element.
- R8: `done` is high for exactly one cycle, in the cycle after the write of the last element of quadrant 3. In that cycle `busy` is already 0.
- R9: A `start` that arrives while `busy` is 1 is ignored. The running operation keeps its latched fields and does not restart.
- R10: `req_valid` is a one-cycle pulse. The first request comes one cycle after the accepted start, and each later request comes one cycle after the previous write. There are exactly 4*DIM*DIM requests per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken only when idle |
| n_field | input | 3 | First-operand register field (register 2*n) |
| m_field | input | 3 | Second-operand register field (register 16+2*m) |
| n_pair | input | 1 | First operand uses a register pair |
| m_pair | input | 1 | Second operand uses a register pair |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| vrf_a_idx | output | 5 | Register-file read index, first operand |
| vrf_a_data | input | VLEN | Register content for vrf_a_idx |
| vrf_b_idx | output | 5 | Register-file read index, second operand |
| vrf_b_data | input | VLEN | Register content for vrf_b_idx |
| tile_addr | output | log2(4*DIM*DIM) | Tile element index for read and write |
| tile_rd_data | input | 16 | Tile content at tile_addr |
| tile_wr_en | output | 1 | Tile write strobe |
| tile_wr_data | output | 16 | Tile write value |
| req_valid | output | 1 | Request pulse to the dot-product unit |
| req_acc | output | 16 | Accumulator operand |
| req_row_op | output | 16 | Row byte pair |
| req_col_op | output | 16 | Column byte pair |
| rsp_valid | input | 1 | Response from the dot-product unit |
| rsp_sum | input | 16 | Updated accumulator value |

## Verification
A request is due exactly one cycle after the accepted start and one cycle after each write. The tile write appears combinationally in the same cycle as the response. The done pulse follows the last write by one cycle. The bench drives inputs on falling edges and samples one falling edge after each step, with a 1-time-unit settle after a response is raised. It demands the request on exactly that edge rather than polling for it, so any slip of a cycle is reported. Random response latencies of 0 to 3 wait cycles are checked cycle by cycle for held outputs, and a stray start is injected in the middle of one run.

// File: rtl/qtm_pkg.sv
package qtm_pkg;

  typedef enum logic [1:0] {
    QS_IDLE  = 2'd0,
    QS_ISSUE = 2'd1,
    QS_WAIT  = 2'd2
  } qtm_state_e;

  localparam int unsigned QTM_REG_W  = 5;
  localparam int unsigned QTM_ELEM_W = 16;

  // Quadrant side in 16-bit elements for a given vector length in bits.
  function automatic int unsigned qtm_quad_dim(input int unsigned vlen_bits);
    return (vlen_bits / 2) / 16;
  endfunction

  // Row-operand register: even register in the low half of the file.
  function automatic logic [4:0] qtm_first_reg(input logic [2:0] field,
                                               input logic       pair,
                                               input logic       col_half);
    logic [4:0] base;
    base = {1'b0, field, 1'b0};
    return base | {4'b0000, pair & col_half};
  endfunction

  // Column-operand register: even register in the high half of the file.
  function automatic logic [4:0] qtm_second_reg(input logic [2:0] field,
                                                input logic       pair,
                                                input logic       row_half);
    logic [4:0] base;
    base = {1'b1, field, 1'b0};
    return base | {4'b0000, pair & row_half};
  endfunction

  // Linear tile index for an absolute row and column.
  function automatic int unsigned qtm_tile_index(input int unsigned row_abs,
                                                 input int unsigned col_abs,
                                                 input int unsigned side);
    return row_abs * side + col_abs;
  endfunction

endpackage

// File: rtl/qtm_walker.sv
module qtm_walker #(
  parameter  int unsigned DIM = 4,
  localparam int unsigned CW  = (DIM > 1) ? $clog2(DIM) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  output logic [1:0]    quad,
  output logic [CW-1:0] row,
  output logic [CW-1:0] col,
  output logic          last_elem
);

  logic col_end;
  logic row_end;

  assign col_end   = (col == CW'(DIM - 1));
  assign row_end   = (row == CW'(DIM - 1));
  assign last_elem = col_end && row_end && (quad == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad <= 2'd0;
      row  <= '0;
      col  <= '0;
    end else if (clear) begin
      quad <= 2'd0;
      row  <= '0;
      col  <= '0;
    end else if (step) begin
      if (col_end) begin
        col <= '0;
        if (row_end) begin
          row  <= '0;
          quad <= quad + 2'd1;
        end else begin
          row <= row + CW'(1);
        end
      end else begin
        col <= col + CW'(1);
      end
    end
  end

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable({quad, row, col})) else $error("walker moved"); // R7

  AST_WALK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_elem && !clear) |=> (quad == 2'd0 && row == '0 && col == '0)) else $error("no wrap"); // R2

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (col <= CW'(DIM - 1)) && (row <= CW'(DIM - 1))) else $error("range"); // R2

endmodule

// File: rtl/qtm_addr_gen.sv
module qtm_addr_gen
  import qtm_pkg::*;
#(
  parameter  int unsigned DIM    = 4,
  localparam int unsigned CW     = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int unsigned SIDE   = 2 * DIM,
  localparam int unsigned IW     = $clog2(SIDE),
  localparam int unsigned TIDX_W = $clog2(SIDE * SIDE)
) (
  input  logic [1:0]        quad,
  input  logic [CW-1:0]     row,
  input  logic [CW-1:0]     col,
  input  logic [2:0]        n_field,
  input  logic [2:0]        m_field,
  input  logic              n_pair,
  input  logic              m_pair,
  output logic [IW-1:0]     row_abs,
  output logic [IW-1:0]     col_abs,
  output logic [TIDX_W-1:0] tile_idx,
  output logic [4:0]        a_reg,
  output logic [4:0]        b_reg
);

  logic row_half;
  logic col_half;
  int unsigned lin;

  assign row_half = quad[1];
  assign col_half = quad[0];

  always_comb begin
    row_abs  = (row_half ? IW'(DIM) : IW'(0)) + IW'(row);
    col_abs  = (col_half ? IW'(DIM) : IW'(0)) + IW'(col);
    lin      = qtm_tile_index(int'(row_abs), int'(col_abs), SIDE);
    tile_idx = lin[TIDX_W-1:0];
    a_reg    = qtm_first_reg(n_field, n_pair, col_half);
    b_reg    = qtm_second_reg(m_field, m_pair, row_half);
  end

endmodule

// File: rtl/qtm_pair_pick.sv
module qtm_pair_pick #(
  parameter  int unsigned VLEN  = 128,
  localparam int unsigned NPAIR = VLEN / 16,
  localparam int unsigned IW    = $clog2(NPAIR)
) (
  input  logic [VLEN-1:0] vec,
  input  logic [IW-1:0]   idx,
  output logic [15:0]     pair
);

  always_comb begin
    pair = '0;
    for (int k = 0; k < int'(NPAIR); k++) begin
      if (idx == IW'(k)) pair = vec[k*16 +: 16];
    end
  end

endmodule

// File: rtl/qtile_mop_seq.sv
module qtile_mop_seq
  import qtm_pkg::*;
#(
  parameter  int unsigned VLEN   = 128,
  localparam int unsigned DIM    = qtm_quad_dim(VLEN),
  localparam int unsigned SIDE   = 2 * DIM,
  localparam int unsigned CW     = (DIM > 1) ? $clog2(DIM) : 1,
  localparam int unsigned IW     = $clog2(SIDE),
  localparam int unsigned TIDX_W = $clog2(SIDE * SIDE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        n_field,
  input  logic [2:0]        m_field,
  input  logic              n_pair,
  input  logic              m_pair,
  output logic              busy,
  output logic              done,
  output logic [4:0]        vrf_a_idx,
  input  logic [VLEN-1:0]   vrf_a_data,
  output logic [4:0]        vrf_b_idx,
  input  logic [VLEN-1:0]   vrf_b_data,
  output logic [TIDX_W-1:0] tile_addr,
  input  logic [15:0]       tile_rd_data,
  output logic              tile_wr_en,
  output logic [15:0]       tile_wr_data,
  output logic              req_valid,
  output logic [15:0]       req_acc,
  output logic [15:0]       req_row_op,
  output logic [15:0]       req_col_op,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_sum
);

  qtm_state_e state_q, state_d;
  logic [2:0] n_q, m_q;
  logic       np_q, mp_q;
  logic       done_q;

  // Named events shared by the FSM, the walker and the assertions.
  logic start_acc;
  logic issue_evt;
  logic accept_evt;
  logic final_evt;

  logic [1:0]    quad;
  logic [CW-1:0] row, col;
  logic          last_elem;
  logic [IW-1:0] row_abs, col_abs;

  logic [VLEN-1:0] side_vec  [2];
  logic [IW-1:0]   side_idx  [2];
  logic [15:0]     side_pair [2];

  assign start_acc  = start && (state_q == QS_IDLE);
  assign issue_evt  = (state_q == QS_ISSUE);
  assign accept_evt = (state_q == QS_WAIT) && rsp_valid;
  assign final_evt  = accept_evt && last_elem;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      QS_IDLE:  if (start_acc) state_d = QS_ISSUE;
      QS_ISSUE: state_d = QS_WAIT;
      QS_WAIT:  if (accept_evt) state_d = last_elem ? QS_IDLE : QS_ISSUE;
      default:  state_d = QS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= QS_IDLE;
      n_q     <= '0;
      m_q     <= '0;
      np_q    <= 1'b0;
      mp_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= final_evt;
      if (start_acc) begin
        n_q  <= n_field;
        m_q  <= m_field;
        np_q <= n_pair;
        mp_q <= m_pair;
      end
    end
  end

  qtm_walker #(.DIM(DIM)) u_walker (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_acc),
    .step      (accept_evt),
    .quad      (quad),
    .row       (row),
    .col       (col),
    .last_elem (last_elem)
  );

  qtm_addr_gen #(.DIM(DIM)) u_addr (
    .quad     (quad),
    .row      (row),
    .col      (col),
    .n_field  (n_q),
    .m_field  (m_q),
    .n_pair   (np_q),
    .m_pair   (mp_q),
    .row_abs  (row_abs),
    .col_abs  (col_abs),
    .tile_idx (tile_addr),
    .a_reg    (vrf_a_idx),
    .b_reg    (vrf_b_idx)
  );

  assign side_vec[0] = vrf_a_data;
  assign side_vec[1] = vrf_b_data;
  assign side_idx[0] = row_abs;
  assign side_idx[1] = col_abs;

  for (genvar s = 0; s < 2; s++) begin : g_side
    qtm_pair_pick #(.VLEN(VLEN)) u_pick (
      .vec  (side_vec[s]),
      .idx  (side_idx[s]),
      .pair (side_pair[s])
    );
  end

  assign busy         = (state_q != QS_IDLE);
  assign done         = done_q;
  assign req_valid    = issue_evt;
  assign req_acc      = tile_rd_data;
  assign req_row_op   = side_pair[0];
  assign req_col_op   = side_pair[1];
  assign tile_wr_en   = accept_evt;
  assign tile_wr_data = rsp_sum;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !req_valid) else $error("request longer than a cycle"); // R10

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable({n_q, m_q, np_q, mp_q})) else $error("start taken while busy"); // R9

  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tile_wr_en)) else $error("done without write"); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy) else $error("done while busy"); // R8

  AST_A_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !np_q) |-> (!vrf_a_idx[0] && !vrf_a_idx[4])) else $error("first reg odd"); // R3

  AST_B_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> vrf_b_idx[4]) else $error("second reg low"); // R4

  AST_WR_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    tile_wr_en |-> $stable(tile_addr)) else $error("address moved before write"); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!req_valid && !tile_wr_en)) else $error("activity while idle"); // R1

endmodule

// File: tb/tb_qtile_mop_seq.sv
module tb_qtile_mop_seq;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned VLEN   = 128;
  localparam int unsigned DIM    = VLEN / 32;
  localparam int unsigned SIDE   = 2 * DIM;
  localparam int unsigned NELEM  = SIDE * SIDE;
  localparam int unsigned TIDX_W = $clog2(NELEM);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] n_field = '0, m_field = '0;
  logic n_pair = 1'b0, m_pair = 1'b0;
  logic busy, done;
  logic [4:0] vrf_a_idx, vrf_b_idx;
  logic [VLEN-1:0] vrf_a_data, vrf_b_data;
  logic [TIDX_W-1:0] tile_addr;
  logic [15:0] tile_rd_data, tile_wr_data;
  logic tile_wr_en, req_valid;
  logic [15:0] req_acc, req_row_op, req_col_op;
  logic rsp_valid = 1'b0;
  logic [15:0] rsp_sum = '0;

  logic [VLEN-1:0] vrf [32];
  logic [15:0] tile_mem [NELEM];
  logic [15:0] shadow [NELEM];

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign vrf_a_data   = vrf[vrf_a_idx];
  assign vrf_b_data   = vrf[vrf_b_idx];
  assign tile_rd_data = tile_mem[tile_addr];

  always @(posedge clk) if (tile_wr_en) tile_mem[tile_addr] <= tile_wr_data;

  qtile_mop_seq #(.VLEN(VLEN)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .n_field(n_field), .m_field(m_field), .n_pair(n_pair), .m_pair(m_pair),
    .busy(busy), .done(done),
    .vrf_a_idx(vrf_a_idx), .vrf_a_data(vrf_a_data),
    .vrf_b_idx(vrf_b_idx), .vrf_b_data(vrf_b_data),
    .tile_addr(tile_addr), .tile_rd_data(tile_rd_data),
    .tile_wr_en(tile_wr_en), .tile_wr_data(tile_wr_data),
    .req_valid(req_valid), .req_acc(req_acc),
    .req_row_op(req_row_op), .req_col_op(req_col_op),
    .rsp_valid(rsp_valid), .rsp_sum(rsp_sum)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int unsigned exp_row_abs(int unsigned q, int unsigned r);
    return (q / 2) * DIM + r;
  endfunction
  function automatic int unsigned exp_col_abs(int unsigned q, int unsigned c);
    return (q % 2) * DIM + c;
  endfunction
  function automatic int unsigned exp_a(int unsigned n, bit np, int unsigned q);
    return 2 * n + (np ? (q % 2) : 0);
  endfunction
  function automatic int unsigned exp_b(int unsigned m, bit mp, int unsigned q);
    return 16 + 2 * m + (mp ? (q / 2) : 0);
  endfunction
  function automatic logic [15:0] unit_sum(logic [15:0] acc, logic [15:0] ro, logic [15:0] co);
    return acc + ro + {co[7:0], co[15:8]};
  endfunction

  task automatic run_op(input int unsigned n, input int unsigned m,
                        input bit np, input bit mp, input bit stray_start);
    int unsigned cnt = 0;
    @(negedge clk);
    n_field = 3'(n); m_field = 3'(m); n_pair = np; m_pair = mp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_field = ~3'(n); m_field = ~3'(m);
    for (int q = 0; q < 4; q++) begin
      for (int r = 0; r < int'(DIM); r++) begin
        for (int c = 0; c < int'(DIM); c++) begin
          int unsigned ri, ci, idx, a, b, lat;
          logic [15:0] ro, co, sum;
          ri  = exp_row_abs(q, r);
          ci  = exp_col_abs(q, c);
          idx = ri * SIDE + ci;
          a   = exp_a(n, np, q);
          b   = exp_b(m, mp, q);
          ro  = vrf[a][16*ri +: 16];
          co  = vrf[b][16*ci +: 16];
          check("R10 request due", 32'(req_valid), 32'd1);
          check("R2 tile_addr", 32'(tile_addr), 32'(idx));
          check("R3 vrf_a_idx", 32'(vrf_a_idx), 32'(a));
          check("R4 vrf_b_idx", 32'(vrf_b_idx), 32'(b));
          check("R5 row operand", 32'(req_row_op), 32'(ro));
          check("R5 col operand", 32'(req_col_op), 32'(co));
          check("R6 accumulator", 32'(req_acc), 32'(shadow[idx]));
          sum = unit_sum(shadow[idx], ro, co);
          shadow[idx] = sum;
          cnt++;
          if (stray_start && cnt == 5) begin
            start = 1'b1; n_pair = ~np; m_pair = ~mp;
          end
          lat = $urandom_range(0, 3);
          @(negedge clk);
          if (stray_start && cnt == 5) begin
            start = 1'b0;
            check("R9 stray start ignored busy", 32'(busy), 32'd1);
            check("R9 stray start no restart", 32'(req_valid), 32'd0);
          end
          for (int w = 0; w < int'(lat); w++) begin
            check("R10 no repeat request", 32'(req_valid), 32'd0);
            check("R7 no write before response", 32'(tile_wr_en), 32'd0);
            check("R7 address held", 32'(tile_addr), 32'(idx));
            @(negedge clk);
          end
          rsp_valid = 1'b1;
          rsp_sum   = sum;
          #1;
          check("R7 write strobe", 32'(tile_wr_en), 32'd1);
          check("R7 write address", 32'(tile_addr), 32'(idx));
          check("R7 write data", 32'(tile_wr_data), 32'(sum));
          check("R8 no early done", 32'(done), 32'd0);
          @(negedge clk);
          rsp_valid = 1'b0;
          rsp_sum   = 16'($urandom);
        end
      end
    end
    check("R10 request count", 32'(cnt), 32'(NELEM));
    check("R8 done pulse", 32'(done), 32'd1);
    check("R8 idle at done", 32'(busy), 32'd0);
    check("R10 no request after last", 32'(req_valid), 32'd0);
    @(negedge clk);
    check("R8 done one cycle", 32'(done), 32'd0);
    begin
      int unsigned bad = 0;
      for (int i = 0; i < int'(NELEM); i++) if (tile_mem[i] !== shadow[i]) bad++;
      check("R6 tile contents", 32'(bad), 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 32; i++)
      for (int w = 0; w < int'(VLEN / 32); w++) vrf[i][32*w +: 32] = $urandom;
    for (int i = 0; i < int'(NELEM); i++) begin
      tile_mem[i] = 16'($urandom);
      shadow[i]   = tile_mem[i];
    end
    repeat (3) @(negedge clk);
    check("R1 busy after reset", 32'(busy), 32'd0);
    check("R1 done after reset", 32'(done), 32'd0);
    check("R1 req_valid after reset", 32'(req_valid), 32'd0);
    check("R1 write after reset", 32'(tile_wr_en), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b1; rsp_sum = 16'hdead;
    #1;
    check("R1 idle response ignored", 32'(tile_wr_en), 32'd0);
    @(negedge clk);
    rsp_valid = 1'b0;
    check("R1 idle stays idle", 32'(busy), 32'd0);

    run_op(0, 0, 1'b0, 1'b0, 1'b0);
    run_op(7, 7, 1'b1, 1'b1, 1'b0);
    run_op($urandom_range(0, 7), $urandom_range(0, 7), 1'b1, 1'b0, 1'b1);
    run_op($urandom_range(0, 7), $urandom_range(0, 7), 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < 3; k++)
      run_op($urandom_range(0, 7), $urandom_range(0, 7),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule